// File: doc/BRIEF.md
# Fault Collection and Attention Classifier

This block gathers one-cycle error event pulses from a link-layer unit into a sticky fault register. Each unmasked fault is sent to one or more of four attention lines: chip checkstop, recoverable, special attention and unit checkstop. Software decides the routing with one routing register per class. Software can inspect and clear the state through a small word-addressed register port with a combinational read path.

Software clears faults by writing the fault register back with the chosen bits at zero. It can also add bits without a read-modify-write through write-only set aliases for the fault and mask registers. A first-error capture register records which bits became set first after it was last zeroed. A two-bit report register latches the link's two fatal-class sources separately, so they survive a fault clear.

Top module: `fault_attn_unit`

## Requirements
- R1: After reset the fault, routing, first-error and report registers read zero, every mask bit reads one, and all four attention lines are low.
- R2: A pulse on event input bit k (k from 0 to 22) sets fault bit k at the next clock edge, and the bit stays set until software overwrites it.
- R3: Event pulses on bits 23 to 44 have no effect, while software writes can set those bits in the fault register.
- R4: A write to offset 0 replaces the fault register. If a hardware event hits the same cycle, the event bit is still set.
- R5: A write to offset 1 ORs the data into the fault register, and a read of offset 1 returns zero.
- R6: A write to offset 2 replaces the mask register, a write to offset 3 ORs the data into it, and a read of offset 3 returns zero.
- R7: Offsets 4, 5, 6 and 7 hold the routing registers for chip checkstop, recoverable, special attention and unit checkstop, in that order, and each reads back its written value.
- R8: Each attention line is the OR over all bits of fault AND NOT mask AND that class's routing register. It follows register state with no further delay.
- R9: While the first-error register (offset 8) is zero, it captures the fault bits that become newly set in a cycle. Once it is nonzero it holds its value until software writes offset 8.
- R10: Offset 9 reads a report register whose bit 0 latches events on source 1 and whose bit 1 latches events on source 2. A write replaces it, and a same-cycle event still sets its bit.
- R11: Reads of offsets 10 to 15 return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtPulse | input | 45 | One-cycle error event pulses, one per fault bit |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word offset |
| regWrData | input | 45 | Write data |
| regRdData | output | 45 | Combinational read data for regAddr |
| chipStopAttn | output | 1 | Chip checkstop attention |
| recovAttn | output | 1 | Recoverable attention |
| specialAttn | output | 1 | Special attention |
| unitStopAttn | output | 1 | Unit checkstop attention |

## Verification
A write or an event lands in its register at the clock edge that follows it. The read data and the four attention lines come from register state with no further delay, so every result is due one edge after its stimulus. The bench drives each stimulus at a falling edge and compares the read data and the attention lines one nanosecond later, before the next rising edge. A bench model updated at that same rising edge supplies the expected values.

// File: rtl/fau_pkg.sv
package fau_pkg;
  localparam int CLASS_N = 4;
  localparam int ADDR_W  = 4;

  typedef enum logic [ADDR_W-1:0] {
    OFS_FAULT     = 4'd0,
    OFS_FAULT_SET = 4'd1,
    OFS_MASK      = 4'd2,
    OFS_MASK_SET  = 4'd3,
    OFS_RT_CHIP   = 4'd4,
    OFS_RT_RECOV  = 4'd5,
    OFS_RT_SPEC   = 4'd6,
    OFS_RT_UNIT   = 4'd7,
    OFS_FIRST     = 4'd8,
    OFS_REPORT    = 4'd9
  } regOfs_e;

  typedef enum logic [2:0] {
    SEL_ZERO, SEL_FAULT, SEL_MASK, SEL_ROUTE, SEL_FIRST, SEL_REPORT
  } rdSel_e;

  typedef struct packed {
    logic               wrFault;
    logic               setFault;
    logic               wrMask;
    logic               setMask;
    logic [CLASS_N-1:0] wrRoute;
    logic               wrFirst;
    logic               wrReport;
  } strobe_t;
endpackage

// File: rtl/fau_ctrl.sv
module fau_ctrl
  import fau_pkg::*;
(
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           strb,
  output rdSel_e            rdSel,
  output logic [1:0]        rdRoute
);
  always_comb begin
    strb    = '0;
    rdSel   = SEL_ZERO;
    rdRoute = regAddr[1:0];
    case (regAddr)
      OFS_FAULT: begin
        strb.wrFault = regWrEn;
        rdSel        = SEL_FAULT;
      end
      OFS_FAULT_SET: strb.setFault = regWrEn;
      OFS_MASK: begin
        strb.wrMask = regWrEn;
        rdSel       = SEL_MASK;
      end
      OFS_MASK_SET: strb.setMask = regWrEn;
      OFS_RT_CHIP, OFS_RT_RECOV, OFS_RT_SPEC, OFS_RT_UNIT: begin
        strb.wrRoute[regAddr[1:0]] = regWrEn;
        rdSel                      = SEL_ROUTE;
      end
      OFS_FIRST: begin
        strb.wrFirst = regWrEn;
        rdSel        = SEL_FIRST;
      end
      OFS_REPORT: begin
        strb.wrReport = regWrEn;
        rdSel         = SEL_REPORT;
      end
      default: ;
    endcase
  end

  always_comb begin
    assert_single_strobe_R11: assert ($onehot0(strb));
  end
endmodule

// File: rtl/fau_datapath.sv
module fau_datapath
  import fau_pkg::*;
#(
  parameter int FAULT_W = 45,
  parameter int SRC_W   = 23,
  parameter int RPT_A   = 1,
  parameter int RPT_B   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  rdSel_e             rdSel,
  input  logic [1:0]         rdRoute,
  input  logic [FAULT_W-1:0] wrData,
  input  logic [FAULT_W-1:0] evtPulse,
  output logic [FAULT_W-1:0] rdData,
  output logic [CLASS_N-1:0] attn
);
  localparam logic [FAULT_W-1:0] DEF_MASK = FAULT_W'((64'd1 << SRC_W) - 64'd1);

  logic [FAULT_W-1:0] faultQ, faultD, maskQ, firstQ, firstBase, newBits, hwSet;
  logic [1:0]         reportQ;
  logic [FAULT_W-1:0] routeQ [CLASS_N];

  assign hwSet = evtPulse & DEF_MASK;

  always_comb begin
    if (strb.wrFault)       faultD = wrData | hwSet;
    else if (strb.setFault) faultD = faultQ | wrData | hwSet;
    else                    faultD = faultQ | hwSet;
  end

  assign newBits   = faultD & ~faultQ;
  assign firstBase = strb.wrFirst ? wrData : firstQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultQ  <= '0;
      maskQ   <= '1;
      firstQ  <= '0;
      reportQ <= '0;
    end else begin
      faultQ <= faultD;
      if (strb.wrMask)       maskQ <= wrData;
      else if (strb.setMask) maskQ <= maskQ | wrData;
      firstQ  <= (firstBase == '0) ? newBits : firstBase;
      reportQ <= (strb.wrReport ? wrData[1:0] : reportQ)
               | {hwSet[RPT_B], hwSet[RPT_A]};
    end
  end

  for (genvar c = 0; c < CLASS_N; c++) begin : g_class
    always_ff @(posedge clk) begin
      if (!rstN)                routeQ[c] <= '0;
      else if (strb.wrRoute[c]) routeQ[c] <= wrData;
    end
    assign attn[c] = |(faultQ & ~maskQ & routeQ[c]);
  end

  always_comb begin
    case (rdSel)
      SEL_FAULT:  rdData = faultQ;
      SEL_MASK:   rdData = maskQ;
      SEL_ROUTE:  rdData = routeQ[rdRoute];
      SEL_FIRST:  rdData = firstQ;
      SEL_REPORT: rdData = {{(FAULT_W-2){1'b0}}, reportQ};
      default:    rdData = '0;
    endcase
  end

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrFault |=> ((faultQ & $past(faultQ)) == $past(faultQ)));

  assert_rsvd_events_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrFault && !strb.setFault) |=>
      (faultQ[FAULT_W-1:SRC_W] == $past(faultQ[FAULT_W-1:SRC_W])));

  assert_hw_set_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((faultQ & $past(hwSet)) == $past(hwSet)));

  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (&maskQ) |-> (attn == '0));

  assert_first_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (firstQ != '0 && !strb.wrFirst) |=> $stable(firstQ));

  assert_report_latch_R10: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse[RPT_A] |=> reportQ[0]);
endmodule

// File: rtl/fault_attn_unit.sv
module fault_attn_unit
  import fau_pkg::*;
#(
  parameter int FAULT_W = 45,
  parameter int SRC_W   = 23
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [FAULT_W-1:0] evtPulse,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [FAULT_W-1:0] regWrData,
  output logic [FAULT_W-1:0] regRdData,
  output logic               chipStopAttn,
  output logic               recovAttn,
  output logic               specialAttn,
  output logic               unitStopAttn
);
  strobe_t            strb;
  rdSel_e             rdSel;
  logic [1:0]         rdRoute;
  logic [CLASS_N-1:0] attn;

  fau_ctrl i_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strb    (strb),
    .rdSel   (rdSel),
    .rdRoute (rdRoute)
  );

  fau_datapath #(.FAULT_W(FAULT_W), .SRC_W(SRC_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rdSel    (rdSel),
    .rdRoute  (rdRoute),
    .wrData   (regWrData),
    .evtPulse (evtPulse),
    .rdData   (regRdData),
    .attn     (attn)
  );

  assign chipStopAttn = attn[0];
  assign recovAttn    = attn[1];
  assign specialAttn  = attn[2];
  assign unitStopAttn = attn[3];
endmodule

// File: tb/test_fault_attn_unit.sv
`timescale 1ns/1ps
module test_fault_attn_unit;
  localparam int W = 45;
  localparam logic [W-1:0] DEFM = W'((64'd1 << 23) - 64'd1);

  logic         clk = 0, rstN = 0, regWrEn = 0;
  logic [W-1:0] evtPulse = '0, regWrData = '0, regRdData;
  logic [3:0]   regAddr = '0;
  logic         chipStopAttn, recovAttn, specialAttn, unitStopAttn;

  int checks = 0, errors = 0;

  logic [W-1:0] mFault, mMask, mFirst;
  logic [W-1:0] mRoute [4];
  logic [1:0]   mRep;

  fault_attn_unit i_fault_attn_unit (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .chipStopAttn(chipStopAttn), .recovAttn(recovAttn),
    .specialAttn(specialAttn), .unitStopAttn(unitStopAttn)
  );

  always #4 clk = ~clk;

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] mRead(input logic [3:0] a);
    case (a)
      4'd0: return mFault;
      4'd2: return mMask;
      4'd4, 4'd5, 4'd6, 4'd7: return mRoute[a[1:0]];
      4'd8: return mFirst;
      4'd9: return {{(W-2){1'b0}}, mRep};
      default: return '0;
    endcase
  endfunction

  function automatic logic [3:0] mAttn();
    logic [3:0] r;
    for (int c = 0; c < 4; c++) r[c] = |(mFault & ~mMask & mRoute[c]);
    return r;
  endfunction

  function automatic logic [W-1:0] rnd45();
    return W'({$urandom(), $urandom()});
  endfunction

  task automatic modelReset();
    mFault = '0; mMask = '1; mFirst = '0; mRep = '0;
    for (int c = 0; c < 4; c++) mRoute[c] = '0;
  endtask

  task automatic step(input bit wr, input logic [3:0] a, input logic [W-1:0] d,
                      input logic [W-1:0] e, input string tag);
    logic [W-1:0] hw, fN, nb, fb;
    regWrEn = wr; regAddr = a; regWrData = d; evtPulse = e;
    #1;
    chk(tag, 64'(regRdData), 64'(mRead(a)));
    chk("R8", 64'({unitStopAttn, specialAttn, recovAttn, chipStopAttn}), 64'(mAttn()));
    hw = e & DEFM;
    if (wr && a == 4'd0)      fN = d | hw;
    else if (wr && a == 4'd1) fN = mFault | d | hw;
    else                      fN = mFault | hw;
    nb = fN & ~mFault;
    fb = (wr && a == 4'd8) ? d : mFirst;
    @(posedge clk);
    mFault = fN;
    mFirst = (fb == '0) ? nb : fb;
    mRep   = ((wr && a == 4'd9) ? d[1:0] : mRep) | {hw[2], hw[1]};
    if (wr && a == 4'd2) mMask = d;
    if (wr && a == 4'd3) mMask = mMask | d;
    if (wr && a >= 4'd4 && a <= 4'd7) mRoute[a[1:0]] = d;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state on every offset
    for (int a = 0; a < 10; a++) step(0, 4'(a), '0, '0, "R1");
    // R2 event sets and stays
    step(0, 0, '0, W'(1), "R2");
    step(0, 0, '0, '0, "R2");
    step(0, 0, '0, '0, "R2");
    // R3 reserved event ignored, defined one taken
    step(0, 0, '0, (W'(1) << 30) | (W'(1) << 5), "R3");
    step(0, 0, '0, '0, "R3");
    // R5 set alias reads zero, R3 software sets reserved bit
    step(1, 1, W'(1) << 40, '0, "R5");
    step(0, 0, '0, '0, "R3");
    // R4 replace with same-cycle event
    step(1, 0, '0, W'(1) << 7, "R4");
    step(0, 0, '0, '0, "R4");
    // R6/R7 mask and routing
    step(1, 2, ~(W'(1) << 7), '0, "R6");
    step(1, 5, W'(1) << 7, '0, "R7");
    step(0, 5, '0, '0, "R7");
    step(1, 3, W'(1) << 7, '0, "R6");
    step(0, 2, '0, '0, "R6");
    // R9 first-error capture
    step(1, 0, '0, '0, "R4");
    step(1, 8, '0, '0, "R9");
    step(0, 8, '0, (W'(1) << 3) | (W'(1) << 4), "R9");
    step(0, 8, '0, W'(1) << 9, "R9");
    step(0, 8, '0, '0, "R9");
    // R10 report register
    step(0, 9, '0, W'(2), "R10");
    step(1, 9, '0, W'(4), "R10");
    step(0, 9, '0, '0, "R10");
    // R11 unmapped offsets
    step(1, 12, '1, '0, "R11");
    step(0, 12, '0, '0, "R11");
    // R7 all classes, mask opened
    step(1, 2, '0, '0, "R6");
    for (int c = 0; c < 4; c++) step(1, 4'(4 + c), W'(1) << (9 + c), '0, "R7");
    step(1, 1, W'(15) << 9, '0, "R8");
    // random phase
    for (int i = 0; i < 800; i++) begin
      logic [3:0] a;
      a = 4'($urandom_range(0, 15));
      step(($urandom_range(0, 3) == 0), a,
           ($urandom_range(0, 1) == 0) ? rnd45() : (rnd45() & rnd45() & rnd45()),
           rnd45() & rnd45() & rnd45() & rnd45(),
           (a == 4'd8) ? "R9" : (a == 4'd9) ? "R10" : (a >= 4'd10) ? "R11" : "R2");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule